// File: doc/BRIEF.md
# Reversible One-Digit Decimal Adder

This block adds two binary-coded decimal digits and a carry-in. It returns one decimal sum digit and a decimal carry-out. There is no clock and no state. It is a structural netlist of bijective reversible primitives, and no primitive output feeds more than one input. Every constant input (ancilla) is tied off inside the block. Every output that the arithmetic does not use (garbage) goes to a debug port, so the garbage count can be seen and checked.

The first stage is a 4-bit ripple adder built from four full-adder gates. Its binary total goes to a 4x4 six-correction gate. That gate forms the decimal carry and passes the three upper sum bits through, so it leaves no garbage. A trimmed second stage then adds 0110 when the decimal carry is set:
- The least significant bit passes straight through.
- A Peres gate handles bit 1.
- A full-adder gate handles bit 2.
- A Feynman gate handles bit 3.

The whole block uses 8 gates, 6 constant inputs and 10 garbage outputs. Its deepest path is 8 gates: 4 in the ripple adder, 1 in the correction gate and 3 in the second stage.

Top module: `bcd_rev_digit`

## Requirements
- R1: For operands 0..9 and carry-in 0 or 1, cout*10 + sum_dig equals a_dig + b_dig + cin.
- R2: For operands 0..9, sum_dig never exceeds 9.
- R3: cout is 1 exactly when the binary total a_dig + b_dig + cin is 10 or more.
- R4: sum_dig[0] equals a_dig[0] XOR b_dig[0] XOR cin, whatever the correction does.
- R5: Each primitive is one-to-one over all of its input codes. This covers the 2-input Feynman gate (4 codes), the 3-input Peres gate (8 codes), the 4-input full-adder gate (16 codes) and the 4-input six-correction gate (16 codes).
- R6: With its fourth input at 0, the full-adder gate's third and fourth outputs form {carry, sum} = a + b + c.
- R7: garbage[3:0] equals a_dig and garbage[7:4] equals b_dig. garbage[8] is bit 2 of the binary total. garbage[9] is cout AND (binary bit 2 OR binary bit 1).
- R8: The six-correction gate maps (x1, x2, x3, k) to (x1, x2, x3, k XOR (x3 AND (x1 OR x2))).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_dig | input | 4 | first decimal operand, 0..9 |
| b_dig | input | 4 | second decimal operand, 0..9 |
| cin | input | 1 | decimal carry-in |
| sum_dig | output | 4 | decimal sum digit |
| cout | output | 1 | decimal carry-out |
| garbage | output | 10 | unused reversible outputs, for debug |

## Verification
The decimal carry has two causes: the binary carry out of the first stage, and the "total is 10 to 15" term (bit 3 AND (bit 2 OR bit 1)). These two causes never hold together, which is why an XOR can stand in for the OR.

The bench covers both sides of that boundary:
- Totals of 16 to 19 (for example 9+9+1 and 8+8) raise only the binary carry.
- Totals of 10 to 15 raise only the range term.
- Totals of 0 to 9 raise neither.

For each total, the bench judges cout, the corrected digit and the correction-stage carry that appears in garbage[9].

// File: rtl/bcd_rev_pkg.sv
package bcd_rev_pkg;
    localparam int DIGIT_W = 4;
    localparam int GARB_W  = 2 * DIGIT_W + 2;
    localparam int ANC_CNT = DIGIT_W + 2;
    typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/rg_feynman.sv
module rg_feynman (
    input  logic a,
    input  logic b,
    output logic p,
    output logic q
);
    always_comb begin
        p = a;
        q = a ^ b;
        if (!$isunknown({a, b})) begin
            AST_FEY_INVERT: assert ((p ^ q) == b && p == a); // R5
        end
    end
endmodule

// File: rtl/rg_peres.sv
module rg_peres (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic p,
    output logic q,
    output logic r
);
    always_comb begin
        p = a;
        q = a ^ b;
        r = (a & b) ^ c;
        if (!$isunknown({a, b, c})) begin
            AST_PER_INVERT: assert (((p & (p ^ q)) ^ r) == c); // R5
        end
    end
endmodule

// File: rtl/rg_hng.sv
module rg_hng (
    input  logic a,
    input  logic b,
    input  logic c,
    input  logic d,
    output logic p,
    output logic q,
    output logic r,
    output logic s
);
    always_comb begin
        p = a;
        q = b;
        r = a ^ b ^ c;
        s = ((a ^ b) & c) ^ ((a & b) ^ d);
        if (!$isunknown({a, b, c, d}) && !d) begin
            AST_HNG_FULLADD: assert ({s, r} == {1'b0, a} + {1'b0, b} + {1'b0, c}); // R6
        end
    end
endmodule

// File: rtl/rg_sixcorr.sv
module rg_sixcorr (
    input  logic x1,
    input  logic x2,
    input  logic x3,
    input  logic k,
    output logic y1,
    output logic y2,
    output logic y3,
    output logic dc
);
    always_comb begin
        y1 = x1;
        y2 = x2;
        y3 = x3;
        dc = k ^ (x3 & (x1 | x2));
        if (!$isunknown({x1, x2, x3, k})) begin
            AST_SCL_PASS:   assert ({y3, y2, y1} == {x3, x2, x1});   // R8
            AST_SCL_INVERT: assert ((dc ^ (y3 & (y1 | y2))) == k);   // R5
        end
    end
endmodule

// File: rtl/rg_ripple.sv
module rg_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   sum,
    output logic           cout,
    output logic [2*W-1:0] garb
);
    logic [W:0] carry;
    assign carry[0] = cin;
    assign cout     = carry[W];

    for (genvar i = 0; i < W; i++) begin : g_stage
        rg_hng u_fa (
            .a (a[i]),
            .b (b[i]),
            .c (carry[i]),
            .d (1'b0),
            .p (garb[i]),
            .q (garb[W+i]),
            .r (sum[i]),
            .s (carry[i+1])
        );
    end
endmodule

// File: rtl/bcd_rev_digit.sv
module bcd_rev_digit
    import bcd_rev_pkg::*;
(
    input  logic [DIGIT_W-1:0] a_dig,
    input  logic [DIGIT_W-1:0] b_dig,
    input  logic               cin,
    output logic [DIGIT_W-1:0] sum_dig,
    output logic               cout,
    output logic [GARB_W-1:0]  garbage
);
    digit_t bin_sum;
    logic   bin_carry;
    logic   x1, x2, x3, dec_c;
    logic   dec_c_a, dec_c_b;
    logic   c1, c2;

    rg_ripple #(.W(DIGIT_W)) u_stage1 (
        .a    (a_dig),
        .b    (b_dig),
        .cin  (cin),
        .sum  (bin_sum),
        .cout (bin_carry),
        .garb (garbage[2*DIGIT_W-1:0])
    );

    rg_sixcorr u_corr (
        .x1 (bin_sum[1]),
        .x2 (bin_sum[2]),
        .x3 (bin_sum[3]),
        .k  (bin_carry),
        .y1 (x1),
        .y2 (x2),
        .y3 (x3),
        .dc (dec_c)
    );

    assign sum_dig[0] = bin_sum[0];

    rg_peres u_bit1 (
        .a (dec_c),
        .b (x1),
        .c (1'b0),
        .p (dec_c_a),
        .q (sum_dig[1]),
        .r (c1)
    );

    rg_hng u_bit2 (
        .a (dec_c_a),
        .b (x2),
        .c (c1),
        .d (1'b0),
        .p (dec_c_b),
        .q (garbage[2*DIGIT_W]),
        .r (sum_dig[2]),
        .s (c2)
    );

    rg_feynman u_bit3 (
        .a (c2),
        .b (x3),
        .p (garbage[2*DIGIT_W+1]),
        .q (sum_dig[3])
    );

    assign cout = dec_c_b;
endmodule

// File: tb/bcd_rev_digit_bench.sv
module bcd_rev_digit_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [3:0] a_dig, b_dig;
    logic       cin;
    logic [3:0] sum_dig;
    logic       cout;
    logic [9:0] garbage;

    bcd_rev_digit u_bcd_rev_digit (
        .a_dig   (a_dig),
        .b_dig   (b_dig),
        .cin     (cin),
        .sum_dig (sum_dig),
        .cout    (cout),
        .garbage (garbage)
    );

    // standalone primitives for one-to-one sweeps
    logic fa, fb, fp, fq;
    logic pa, pb, pc, pp, pq, pr;
    logic ha, hb, hc, hd, hp, hq, hr, hs;
    logic sx1, sx2, sx3, sk, sy1, sy2, sy3, sdc;
    rg_feynman t_fey (.a(fa), .b(fb), .p(fp), .q(fq));
    rg_peres   t_per (.a(pa), .b(pb), .c(pc), .p(pp), .q(pq), .r(pr));
    rg_hng     t_hng (.a(ha), .b(hb), .c(hc), .d(hd), .p(hp), .q(hq), .r(hr), .s(hs));
    rg_sixcorr t_scl (.x1(sx1), .x2(sx2), .x3(sx3), .k(sk),
                      .y1(sy1), .y2(sy2), .y3(sy3), .dc(sdc));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard: {a, b, cin}
    logic [8:0] exp_q[$];

    task automatic drive(input logic [3:0] a, input logic [3:0] b, input logic c);
        @(posedge clk);
        #1;
        a_dig = a; b_dig = b; cin = c;
        exp_q.push_back({a, b, c});
    endtask

    always @(negedge clk) begin
        if (!rst && exp_q.size() > 0) begin
            logic [8:0] it;
            int tot, ea, eb, ec, es;
            logic [4:0] bs;
            logic [9:0] eg;
            it = exp_q.pop_front();
            ea = int'(it[8:5]); eb = int'(it[4:1]); ec = int'(it[0]);
            tot = ea + eb + ec;
            bs  = 5'(tot);
            es  = (tot >= 10) ? tot - 10 : tot;
            chk((int'(cout) * 10 + int'(sum_dig)) == tot, "R1 decimal total",
                int'(cout) * 10 + int'(sum_dig), tot);
            chk(sum_dig <= 4'd9 && int'(sum_dig) == es, "R2 digit range",
                int'(sum_dig), es);
            chk(cout == (tot >= 10), "R3 carry", int'(cout), int'(tot >= 10));
            chk(sum_dig[0] == (it[5] ^ it[1] ^ it[0]), "R4 bit0 pass",
                int'(sum_dig[0]), int'(it[5] ^ it[1] ^ it[0]));
            eg = {(tot >= 10) & (bs[2] | bs[1]), bs[2], it[4:1], it[8:5]};
            chk(garbage == eg, "R7 garbage layout", int'(garbage), int'(eg));
        end
    end

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        a_dig = 4'd0; b_dig = 4'd0; cin = 1'b0;
        fa = 0; fb = 0; pa = 0; pb = 0; pc = 0;
        ha = 0; hb = 0; hc = 0; hd = 0; sx1 = 0; sx2 = 0; sx3 = 0; sk = 0;
        #1;

        // R5: Feynman one-to-one
        begin
            bit seen[4];
            bit dup = 0;
            foreach (seen[i]) seen[i] = 0;
            for (int v = 0; v < 4; v++) begin
                {fa, fb} = 2'(v); #1;
                if (seen[{fp, fq}]) dup = 1;
                seen[{fp, fq}] = 1;
            end
            chk(!dup, "R5 feynman bijective", int'(dup), 0);
        end
        // R5: Peres one-to-one
        begin
            bit seen[8];
            bit dup = 0;
            foreach (seen[i]) seen[i] = 0;
            for (int v = 0; v < 8; v++) begin
                {pa, pb, pc} = 3'(v); #1;
                if (seen[{pp, pq, pr}]) dup = 1;
                seen[{pp, pq, pr}] = 1;
            end
            chk(!dup, "R5 peres bijective", int'(dup), 0);
        end
        // R5 and R6: full-adder gate
        begin
            bit seen[16];
            bit dup = 0;
            foreach (seen[i]) seen[i] = 0;
            for (int v = 0; v < 16; v++) begin
                {ha, hb, hc, hd} = 4'(v); #1;
                if (seen[{hp, hq, hr, hs}]) dup = 1;
                seen[{hp, hq, hr, hs}] = 1;
                if (!hd)
                    chk(int'({hs, hr}) == int'(ha) + int'(hb) + int'(hc), "R6 full add",
                        int'({hs, hr}), int'(ha) + int'(hb) + int'(hc));
            end
            chk(!dup, "R5 hng bijective", int'(dup), 0);
        end
        // R5 and R8: six-correction gate
        begin
            bit seen[16];
            bit dup = 0;
            logic [3:0] ex;
            foreach (seen[i]) seen[i] = 0;
            for (int v = 0; v < 16; v++) begin
                {sx1, sx2, sx3, sk} = 4'(v); #1;
                if (seen[{sy1, sy2, sy3, sdc}]) dup = 1;
                seen[{sy1, sy2, sy3, sdc}] = 1;
                ex = {sx1, sx2, sx3, sk ^ (sx3 & (sx1 | sx2))};
                chk({sy1, sy2, sy3, sdc} == ex, "R8 correction map",
                    int'({sy1, sy2, sy3, sdc}), int'(ex));
            end
            chk(!dup, "R5 sixcorr bijective", int'(dup), 0);
        end

        repeat (3) @(posedge clk);
        #1;
        chk(sum_dig == 4'd0 && cout == 1'b0, "R1 reset state zero",
            int'({cout, sum_dig}), 0);
        rst = 1'b0;

        // binary-carry-only corner cases (R3) then full sweep
        drive(4'd9, 4'd9, 1'b1);
        drive(4'd8, 4'd8, 1'b0);
        drive(4'd5, 4'd5, 1'b0);
        drive(4'd9, 4'd0, 1'b0);
        drive(4'd9, 4'd0, 1'b1);
        for (int x = 0; x < 10; x++)
            for (int y = 0; y < 10; y++)
                for (int c = 0; c < 2; c++)
                    drive(4'(x), 4'(y), 1'(c));

        @(posedge clk);
        @(posedge clk);
        while (exp_q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule